// File: doc/BRIEF.md
# Binary Strip Hit Pipeline and Trigger Derandomizer

This block is the digital back end of a group of binary strip channels. On every bunch-crossing clock it registers one discriminator bit per channel and forces disabled channels to zero. The registered word then enters a circular latency ring, where it waits for the level-1 trigger decision.

When a trigger arrives, the block takes three consecutive crossings from the ring in a single clock cycle. These are the crossing at the programmed latency and its two neighbours. The three words go into an event queue as one event. The readout side takes events out of the queue in arrival order, one word per handshake, in the same clock domain.

A trigger that finds the queue full is discarded and sets a sticky overflow flag. Reset clears the ring, the queue and the flag. Reset does not touch the channel mask.

Top module: `strip_hit_pipe`

## Requirements
- R1: Each bit of `mask_data` set to 1 disables that channel. A disabled channel reads 0 in every event word, whatever its hit input does.
- R2: A cycle with `mask_we` high loads the whole mask from `mask_data`. The new mask applies to crossings sampled from the next clock edge onward. The mask keeps its value through reset.
- R3: Let e be a clock edge counted from 1 at the first edge after reset is released, and let L be `lat_cfg` at that edge. A trigger sampled at edge e queues one event with three words:
  - `rd_idx` 0 carries the masked hit vector sampled at edge e−L−2;
  - `rd_idx` 1 carries the vector sampled at edge e−L−1;
  - `rd_idx` 2 carries the vector sampled at edge e−L.
  Crossings at edges below 1 read as zero.
- R4: `lat_cfg` may take any value from 2 to PIPE_DEPTH−1. A new value applies to every trigger sampled after the change.
- R5: Triggers on consecutive clock edges each queue their own event, with windows that overlap.
- R6: The output offers data while `rd_valid` is high. A word is taken on a clock edge where `rd_valid` and `rd_ready` are both high. The three words of an event come out in `rd_idx` order 0, 1, 2, and events come out in the order their triggers arrived. While `rd_ready` is low, the word and index stay stable.
- R7: A trigger sampled while EVT_DEPTH events are stored is dropped, even if a word is taken on the same edge. The drop sets `ovf_flag`, which stays high until reset. Events already stored come out unchanged.
- R8: `empty_flag` is high exactly when no event, or part of an event, remains in the queue.
- R9: Reset clears the latency ring, the event queue and `ovf_flag`. After reset `rd_valid` is 0 and `empty_flag` is 1.
- R10: The queue holds up to EVT_DEPTH complete events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_in | input | N_CH | Discriminator bits of the current crossing |
| trig_in | input | 1 | Level-1 trigger, one cycle per trigger |
| lat_cfg | input | LAT_W | Trigger latency in crossings |
| mask_we | input | 1 | Load the channel mask |
| mask_data | input | N_CH | New mask, 1 disables a channel |
| rd_ready | input | 1 | Readout side accepts a word |
| rd_word | output | N_CH | Word at the queue head |
| rd_idx | output | 2 | Position of the word inside its event |
| rd_valid | output | 1 | A word is offered |
| ovf_flag | output | 1 | Sticky trigger drop flag |
| empty_flag | output | 1 | Queue holds nothing |

## Verification
The assertions rely on three properties of the inputs:
- `lat_cfg` is at least 2 whenever a trigger is sampled;
- PIPE_DEPTH is a power of two;
- the mask is loaded while reset is asserted, so it is never undefined after reset.

The stimulus holds latency inside the legal range in every phase, including a sweep over all legal values. It loads the mask during the first reset and changes it only between trigger bursts. It randomises `rd_ready` only in phases where stalls are meant to be exercised.

// File: rtl/strip_pipe_pkg.sv
package strip_pipe_pkg;
  // crossings copied per trigger
  localparam int WIN = 3;

  // ring slot of window word k; the middle word sits at (wr - lat)
  function automatic int win_slot(int wr, int lat, int k, int depth);
    return (wr - lat - (WIN - 1) / 2 + k + 2 * depth) % depth;
  endfunction

  // wrap-around increment for a queue of arbitrary size
  function automatic int ring_next(int p, int size);
    return (p == size - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/hit_capture.sv
module hit_capture #(
  parameter int N_CH = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] hit_in,
  input  logic            mask_we,
  input  logic [N_CH-1:0] mask_data,
  output logic [N_CH-1:0] cap_word
);
  logic [N_CH-1:0] mask_q;
  logic [N_CH-1:0] cap_q;

  // mask survives reset on purpose
  always_ff @(posedge clk) begin
    if (mask_we) mask_q <= mask_data;
  end

  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else     cap_q <= hit_in & ~mask_q;
  end

  assign cap_word = cap_q;

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    $stable(mask_q) |-> ((cap_q & mask_q) == '0)); // R1
endmodule

// File: rtl/latency_ring.sv
module latency_ring
  import strip_pipe_pkg::*;
#(
  parameter int N_CH       = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int LAT_W      = $clog2(PIPE_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_CH-1:0]     wr_word,
  input  logic [LAT_W-1:0]    lat,
  output logic [WIN*N_CH-1:0] win_flat
);
  localparam int PTR_W = $clog2(PIPE_DEPTH);

  logic [N_CH-1:0]  ring_mem [PIPE_DEPTH];
  logic [PTR_W-1:0] wp;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      for (int i = 0; i < PIPE_DEPTH; i++) ring_mem[i] <= '0;
    end else begin
      ring_mem[wp] <= wr_word;
      wp           <= wp + PTR_W'(1);
    end
  end

  // one read port per window word, all read in the trigger cycle
  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic [PTR_W-1:0] slot;
    assign slot = PTR_W'(win_slot(int'(wp), int'(lat), k, PIPE_DEPTH));
    assign win_flat[k*N_CH +: N_CH] = ring_mem[slot];
  end
endmodule

// File: rtl/event_fifo.sv
module event_fifo
  import strip_pipe_pkg::*;
#(
  parameter int N_CH      = 128,
  parameter int EVT_DEPTH = 43
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [WIN*N_CH-1:0] push_words,
  input  logic                rd_ready,
  output logic [N_CH-1:0]     rd_word,
  output logic [1:0]          rd_idx,
  output logic                rd_valid,
  output logic                empty_flag,
  output logic                ovf_flag
);
  localparam int EW    = WIN * N_CH;
  localparam int PTR_W = $clog2(EVT_DEPTH);
  localparam int CNT_W = $clog2(EVT_DEPTH + 1);

  logic [EW-1:0]    ev_mem [EVT_DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sub;
  logic             ovf_q;

  // named internal events
  logic full, push_ok, push_drop, beat, pop_evt;
  assign full      = (cnt == CNT_W'(EVT_DEPTH));
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign rd_valid  = (cnt != '0);
  assign beat      = rd_valid && rd_ready;
  assign pop_evt   = beat && (sub == 2'(WIN - 1));

  always_ff @(posedge clk) begin
    if (push_ok) ev_mem[wp] <= push_words;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      sub   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok)   wp <= PTR_W'(ring_next(int'(wp), EVT_DEPTH));
      if (pop_evt)   rp <= PTR_W'(ring_next(int'(rp), EVT_DEPTH));
      if (beat)      sub <= pop_evt ? 2'd0 : sub + 2'd1;
      if (push_drop) ovf_q <= 1'b1;
      unique case ({push_ok, pop_evt})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_word    = ev_mem[rp][int'(sub)*N_CH +: N_CH];
  assign rd_idx     = sub;
  assign empty_flag = !rd_valid;
  assign ovf_flag   = ovf_q;

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    push_drop |=> ovf_flag); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag); // R7
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(EVT_DEPTH)); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_word) && $stable(rd_idx))); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_idx < 2'(WIN))); // R3
endmodule

// File: rtl/strip_hit_pipe.sv
module strip_hit_pipe
  import strip_pipe_pkg::*;
#(
  parameter int N_CH       = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int EVT_DEPTH  = 43,
  parameter int LAT_W      = $clog2(PIPE_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  hit_in,
  input  logic             trig_in,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic             mask_we,
  input  logic [N_CH-1:0]  mask_data,
  input  logic             rd_ready,
  output logic [N_CH-1:0]  rd_word,
  output logic [1:0]       rd_idx,
  output logic             rd_valid,
  output logic             ovf_flag,
  output logic             empty_flag
);
  logic [N_CH-1:0]     cap_word;
  logic [WIN*N_CH-1:0] win_flat;

  hit_capture #(.N_CH(N_CH)) cap_i (
    .clk(clk), .rst(rst), .hit_in(hit_in),
    .mask_we(mask_we), .mask_data(mask_data), .cap_word(cap_word)
  );

  latency_ring #(.N_CH(N_CH), .PIPE_DEPTH(PIPE_DEPTH), .LAT_W(LAT_W)) ring_i (
    .clk(clk), .rst(rst), .wr_word(cap_word), .lat(lat_cfg), .win_flat(win_flat)
  );

  event_fifo #(.N_CH(N_CH), .EVT_DEPTH(EVT_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(trig_in), .push_words(win_flat),
    .rd_ready(rd_ready), .rd_word(rd_word), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .empty_flag(empty_flag), .ovf_flag(ovf_flag)
  );

  AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    trig_in |-> (lat_cfg >= LAT_W'(2))); // R4
endmodule

// File: tb/strip_hit_pipe_tb_top.sv
`timescale 1ns/1ps
module strip_hit_pipe_tb_top;
  localparam int N = 8, PD = 16, ED = 4, LW = $clog2(PD), HSZ = 16384;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] hit_in = '0;
  logic trig_in = 1'b0;
  logic [LW-1:0] lat_cfg = LW'(2);
  logic mask_we = 1'b0;
  logic [N-1:0] mask_data = '0;
  logic rd_ready = 1'b0;
  logic [N-1:0] rd_word;
  logic [1:0] rd_idx;
  logic rd_valid, ovf_flag, empty_flag;

  always #2.5 clk = ~clk;

  strip_hit_pipe #(.N_CH(N), .PIPE_DEPTH(PD), .EVT_DEPTH(ED)) dut_i (
    .clk(clk), .rst(rst), .hit_in(hit_in), .trig_in(trig_in), .lat_cfg(lat_cfg),
    .mask_we(mask_we), .mask_data(mask_data), .rd_ready(rd_ready),
    .rd_word(rd_word), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .ovf_flag(ovf_flag), .empty_flag(empty_flag)
  );

  int tests = 0, fails = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model -------------------
  int edge_n = 0;
  logic [N-1:0] hist [HSZ];
  logic [N-1:0] mask_m = '0;
  logic [N-1:0] qw [ED][3];
  int q_head = 0, q_cnt = 0, q_sub = 0;
  bit exp_ovf = 0;

  function automatic logic [N-1:0] hget(int c);
    if (c < 1) return '0;
    return hist[c % HSZ];
  endfunction

  function automatic logic [N-1:0] pat(int c);
    return N'(c * 37 + 5);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      edge_n = 0; q_head = 0; q_cnt = 0; q_sub = 0; exp_ovf = 0;
    end else begin
      int cb, hb, tail;
      edge_n++;
      cb = q_cnt; hb = q_head;
      if (cb > 0 && rd_ready) begin
        if (q_sub == 2) begin q_sub = 0; q_head = (q_head + 1) % ED; q_cnt--; end
        else q_sub++;
      end
      if (trig_in) begin
        if (cb == ED) exp_ovf = 1;
        else begin
          tail = (hb + cb) % ED;
          for (int k = 0; k < 3; k++) qw[tail][k] = hget(edge_n - int'(lat_cfg) - 2 + k);
          q_cnt++;
        end
      end
      hist[edge_n % HSZ] = hit_in & ~mask_m;
    end
    if (mask_we) mask_m = mask_data;
  end

  // ---------------- per-cycle monitor -------------------
  bit mon_en = 0;
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      chk(rd_valid == (q_cnt > 0), "R6 valid", 64'(rd_valid), 64'(q_cnt > 0));
      chk(empty_flag == (q_cnt == 0), "R8 empty", 64'(empty_flag), 64'(q_cnt == 0));
      chk(ovf_flag == exp_ovf, "R7 overflow", 64'(ovf_flag), 64'(exp_ovf));
      if (q_cnt > 0) begin
        chk(rd_word == qw[q_head][q_sub], "R3 word", 64'(rd_word), 64'(qw[q_head][q_sub]));
        chk(rd_idx == 2'(q_sub), "R6 idx", 64'(rd_idx), 64'(q_sub));
      end
    end
  end

  // ---------------- stimulus -------------------
  int hit_mode = 0;
  bit rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (hit_mode)
      0: hit_in = lfsr[N-1:0];
      1: hit_in = '1;
      2: hit_in = '0;
      default: hit_in = pat(edge_n + 1);
    endcase
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      if (rdy_rand) rd_ready = lfsr[5] | lfsr[9];
    end
  endtask

  task automatic fire(output int e);
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    e = edge_n;
  endtask

  task automatic take_event(output logic [N-1:0] w [3]);
    rd_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(rd_valid == 1'b1, "R6 event present", 64'(rd_valid), 64'd1);
      chk(rd_idx == 2'(k), "R6 word order", 64'(rd_idx), 64'(k));
      w[k] = rd_word;
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [N-1:0] w [3];
    int e, e2, e3, beats;
    // load mask while held in reset
    mask_we = 1'b1; mask_data = 8'h21;
    @(negedge clk);
    mask_we = 1'b0;
    step(2);
    chk(rd_valid == 1'b0, "R9 reset valid", 64'(rd_valid), 64'd0);
    chk(empty_flag == 1'b1, "R9 reset empty", 64'(empty_flag), 64'd1);
    chk(ovf_flag == 1'b0, "R9 reset ovf", 64'(ovf_flag), 64'd0);
    rst = 1'b0;
    mon_en = 1;
    step(1);
    chk(empty_flag == 1'b1, "R8 idle empty", 64'(empty_flag), 64'd1);

    // R1: all channels hit, masked ones must read zero
    hit_mode = 1; lat_cfg = LW'(3);
    step(10);
    fire(e);
    take_event(w);
    for (int k = 0; k < 3; k++) chk(w[k] == 8'hDE, "R1 mask applied", 64'(w[k]), 64'hDE);

    // R3/R4: arithmetic pattern at several latencies
    hit_mode = 3;
    foreach (w[i]) w[i] = '0;
    for (int li = 0; li < 4; li++) begin
      int L;
      L = (li == 0) ? 2 : (li == 1) ? 5 : (li == 2) ? 9 : PD - 1;
      lat_cfg = LW'(L);
      step(20);
      fire(e);
      take_event(w);
      for (int k = 0; k < 3; k++)
        chk(w[k] == (pat(e - L - 2 + k) & ~8'h21), "R3 R4 window", 64'(w[k]),
            64'(pat(e - L - 2 + k) & ~8'h21));
    end

    // R4/R6: sweep of every legal latency with random stalls and paired triggers
    hit_mode = 0; rdy_rand = 1;
    for (int L = 2; L < PD; L++) begin
      lat_cfg = LW'(L);
      step(12);
      fire(e);
      step(3);
      fire(e); fire(e2);
      step(14);
    end
    rdy_rand = 0; rd_ready = 1'b1;
    step(40);
    rd_ready = 1'b0;
    chk(empty_flag == 1'b1, "R8 drained", 64'(empty_flag), 64'd1);

    // R5: three triggers on consecutive edges
    hit_mode = 3; lat_cfg = LW'(4);
    step(10);
    fire(e); fire(e2); fire(e3);
    chk(e2 == e + 1 && e3 == e + 2, "R5 consecutive edges", 64'(e3 - e), 64'd2);
    for (int t = 0; t < 3; t++) begin
      take_event(w);
      for (int k = 0; k < 3; k++)
        chk(w[k] == (pat(e + t - 6 + k) & ~8'h21), "R5 per-trigger event", 64'(w[k]),
            64'(pat(e + t - 6 + k) & ~8'h21));
    end

    // R7/R10: overflow with the reader stalled
    hit_mode = 0;
    step(4);
    for (int t = 0; t < ED + 2; t++) begin fire(e); step(1); end
    chk(ovf_flag == 1'b1, "R7 overflow set", 64'(ovf_flag), 64'd1);
    rd_ready = 1'b1;
    beats = 0;
    while (rd_valid) begin beats++; @(negedge clk); end
    rd_ready = 1'b0;
    chk(beats == ED * 3, "R10 capacity", 64'(beats), 64'(ED * 3));
    chk(ovf_flag == 1'b1, "R7 sticky", 64'(ovf_flag), 64'd1);
    chk(empty_flag == 1'b1, "R8 empty after drain", 64'(empty_flag), 64'd1);

    // R9: reset clears ring and overflow, keeps mask
    hit_mode = 1;
    step(20);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    lat_cfg = LW'(10);
    step(1);
    chk(ovf_flag == 1'b0, "R9 ovf cleared", 64'(ovf_flag), 64'd0);
    chk(empty_flag == 1'b1, "R9 queue cleared", 64'(empty_flag), 64'd1);
    fire(e);
    take_event(w);
    for (int k = 0; k < 3; k++) chk(w[k] == '0, "R9 ring cleared", 64'(w[k]), 64'd0);

    // R2: mask kept through reset, then reloaded
    lat_cfg = LW'(2);
    step(10);
    fire(e);
    take_event(w);
    for (int k = 0; k < 3; k++) chk(w[k] == 8'hDE, "R2 mask kept", 64'(w[k]), 64'hDE);
    mask_we = 1'b1; mask_data = 8'h0F;
    step(1);
    mask_we = 1'b0;
    step(8);
    fire(e);
    take_event(w);
    for (int k = 0; k < 3; k++) chk(w[k] == 8'hF0, "R2 mask reload", 64'(w[k]), 64'hF0);

    step(4);
    finish_run();
  end
endmodule